// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Exception Entry

This block is the hardwired sequencer for a multicycle processor datapath. A 4-bit state register walks through these phases in order: instruction fetch, decode and operand read, then a short execute, memory and write-back sequence chosen by the opcode class. In every state a decoder drives the datapath's select and write-enable lines. Those lines cover the ALU operation and operand selects, the register-file write controls, the memory read and write strobes, the instruction-register load, the PC write and its source select.

Two faults leave the normal flow. An opcode outside the supported set is caught in decode. An ALU overflow is caught in the register-register execute step. Each fault leads to a one-cycle exception state. In that cycle the ALU forms PC−4, which is the address of the faulting instruction because fetch has already advanced the PC. That value is written into the exception PC register. A cause code is written, and the PC is loaded from the fixed exception vector, which the datapath supplies as PC-source input 3. The next cycle is an ordinary fetch at the vector. The current state encoding is also brought out, so the datapath can use it and so can debug.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it drops, the state is 0000 (fetch). In fetch, `mem_rd`=1, `addr_sel`=0 (PC), `ir_wr`=1, the ALU adds (`alu_op`=00) with A from the PC (`alu_a_sel`=0) and B the constant 4 (`alu_b_sel`=001), and `pc_wr`=1 with `pc_src`=00 (ALU result). The next state is always 0001 (decode).
- R2: From decode (0001) the next state depends on `opcode`: 000000 leads to 0100, 001101 to 0110, 100011 to 1000, 101011 to 1011, 000100 to 0010, and 000010 to 1101.
- R3: Any other opcode in decode leads to state 1110. In 1110, `epc_wr`=1 with the ALU subtracting (`alu_op`=01) the constant 4 (`alu_b_sel`=001) from the PC (`alu_a_sel`=0). Also, `cause_wr`=1 with `cause_code`=10, and `pc_wr`=1 with `pc_src`=11 (exception vector). The next state is fetch.
- R4: State 0100 drives `alu_op`=10 (function field), `alu_a_sel`=1 and `alu_b_sel`=000. Without overflow it goes to 0101, where `reg_wr`=1, `reg_dst`=1 (rd) and `wb_sel`=0 (ALU). After 0101 comes fetch.
- R5: With `alu_ovf` high in state 0100, the next state is 1111. That state has the same EPC, PC and ALU controls as 1110, but `cause_code`=12, and `reg_wr` stays 0. The next state is fetch.
- R6: State 0110 drives `alu_op`=11 (OR) with `alu_b_sel`=100 (zero-extended immediate), and `alu_ovf` has no effect there. It always goes to 0111, which writes register rt (`reg_wr`=1, `reg_dst`=0, `wb_sel`=0). After 0111 comes fetch.
- R7: Load runs 1000 → 1001 → 1010 → fetch. In 1000 the ALU adds with `alu_a_sel`=1 and `alu_b_sel`=010 (sign-extended offset). In 1001, `mem_rd`=1 with `addr_sel`=1. In 1010, `reg_wr`=1, `wb_sel`=1 and `reg_dst`=0.
- R8: Store runs 1011 → 1100 → fetch. State 1011 forms the address the same way as 1000. State 1100 drives `mem_wr`=1 with `addr_sel`=1.
- R9: State 0010 subtracts register B from register A (`alu_op`=01, `alu_a_sel`=1, `alu_b_sel`=000). With `alu_equal` high it goes to 0011, otherwise to fetch. State 0011 adds the shifted sign-extended offset to the PC (`alu_a_sel`=0, `alu_b_sel`=011, `alu_op`=00) and drives `pc_wr`=1 with `pc_src`=00. After 0011 comes fetch.
- R10: State 1101 drives `pc_wr`=1 with `pc_src`=10 (jump target) and then returns to fetch.
- R11: Every control output not named above for a state is 0 in that state. Decode drives all of them to 0, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W | Opcode field of the instruction register |
| alu_equal | input | 1 | ALU zero flag |
| alu_ovf | input | 1 | ALU signed overflow flag |
| state_o | output | 4 | Current state encoding |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 OR |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 3 | ALU B operand: 000 reg B, 001 four, 010 sign-ext, 011 sign-ext shifted, 100 zero-ext |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination: 0 rt, 1 rd |
| wb_sel | output | 1 | Write data: 0 ALU, 1 memory |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | PC write |
| pc_src | output | 2 | PC source: 00 ALU, 01 branch target, 10 jump, 11 exception vector |
| epc_wr | output | 1 | Exception PC write (from ALU: PC−4) |
| cause_wr | output | 1 | Cause register write |
| cause_code | output | CAUSE_W | Cause value, zero when not writing |

## Verification
The bench builds the block with its default parameters. These are a 6-bit opcode with the six supported encodings listed in R2, a 4-bit cause code, and the cause values 10 and 12. With these defaults every one of the sixteen state encodings can be reached. The instruction mix drives both exception paths, and it also applies overflow where it must be ignored, in the OR-immediate and load steps. Further cases are a not-equal branch, two different unsupported opcodes, and a reset applied in the middle of a load.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_BEQ_CMP   = 4'd2,
        ST_BEQ_TAKE  = 4'd3,
        ST_R_EXE     = 4'd4,
        ST_R_WB      = 4'd5,
        ST_ORI_EXE   = 4'd6,
        ST_ORI_WB    = 4'd7,
        ST_LW_ADDR   = 4'd8,
        ST_LW_MEM    = 4'd9,
        ST_LW_WB     = 4'd10,
        ST_SW_ADDR   = 4'd11,
        ST_SW_MEM    = 4'd12,
        ST_JMP       = 4'd13,
        ST_EXC_UNDEF = 4'd14,
        ST_EXC_OVF   = 4'd15
    } mc_state_t;

    typedef enum logic [2:0] {
        CLS_R, CLS_ORI, CLS_LW, CLS_SW, CLS_BEQ, CLS_JMP, CLS_BAD
    } op_class_t;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2, ALU_OR = 2'd3
    } alu_op_t;

    typedef enum logic [2:0] {
        SRCB_RT = 3'd0, SRCB_FOUR = 3'd1, SRCB_SEXT = 3'd2,
        SRCB_SEXT_SH2 = 3'd3, SRCB_ZEXT = 3'd4
    } srcb_t;

    typedef enum logic [1:0] {
        PCS_ALU = 2'd0, PCS_TARGET = 2'd1, PCS_JUMP = 2'd2, PCS_EXC = 2'd3
    } pcsrc_t;

    typedef struct packed {
        alu_op_t alu_op;
        logic    srca_reg;
        srcb_t   srcb;
        logic    reg_wr;
        logic    dst_rd;
        logic    wb_mem;
        logic    mem_rd;
        logic    mem_wr;
        logic    addr_alu;
        logic    ir_wr;
        logic    pc_wr;
        pcsrc_t  pc_src;
        logic    epc_wr;
        logic    cause_wr;
        logic    cause_ovf;
    } ctl_t;

    function automatic ctl_t ctl_idle();
        ctl_t c;
        c = '0;
        return c;
    endfunction

    // Shared control pattern of both exception states: EPC <= PC - 4, PC <= vector.
    function automatic ctl_t ctl_exc_entry(input logic is_ovf);
        ctl_t c;
        c           = '0;
        c.alu_op    = ALU_SUB;
        c.srca_reg  = 1'b0;
        c.srcb      = SRCB_FOUR;
        c.epc_wr    = 1'b1;
        c.cause_wr  = 1'b1;
        c.cause_ovf = is_ovf;
        c.pc_wr     = 1'b1;
        c.pc_src    = PCS_EXC;
        return c;
    endfunction

    // Address step shared by load and store.
    function automatic ctl_t ctl_addr_calc();
        ctl_t c;
        c          = '0;
        c.alu_op   = ALU_ADD;
        c.srca_reg = 1'b1;
        c.srcb     = SRCB_SEXT;
        return c;
    endfunction

endpackage

// File: rtl/mc_opclass.sv
module mc_opclass
    import mc_ctrl_pkg::*;
#(
    parameter int              OP_W    = 6,
    parameter logic [OP_W-1:0] OPC_R   = 6'b000000,
    parameter logic [OP_W-1:0] OPC_ORI = 6'b001101,
    parameter logic [OP_W-1:0] OPC_LW  = 6'b100011,
    parameter logic [OP_W-1:0] OPC_SW  = 6'b101011,
    parameter logic [OP_W-1:0] OPC_BEQ = 6'b000100,
    parameter logic [OP_W-1:0] OPC_JMP = 6'b000010
) (
    input  logic [OP_W-1:0] opcode,
    output op_class_t       op_class
);
    localparam int N_CLS = 6;

    logic [N_CLS-1:0]      hit;
    logic [N_CLS*OP_W-1:0] codes;

    assign codes = {OPC_JMP, OPC_BEQ, OPC_SW, OPC_LW, OPC_ORI, OPC_R};

    for (genvar g = 0; g < N_CLS; g++) begin : g_match
        assign hit[g] = (opcode == codes[g*OP_W +: OP_W]);
    end

    // Lowest index wins if two opcode parameters are ever set equal.
    always_comb begin
        op_class = CLS_BAD;
        if      (hit[0]) op_class = CLS_R;
        else if (hit[1]) op_class = CLS_ORI;
        else if (hit[2]) op_class = CLS_LW;
        else if (hit[3]) op_class = CLS_SW;
        else if (hit[4]) op_class = CLS_BEQ;
        else if (hit[5]) op_class = CLS_JMP;
    end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  mc_state_t state,
    input  op_class_t op_class,
    input  logic      alu_equal,
    input  logic      alu_ovf,
    output mc_state_t nxt
);
    always_comb begin
        nxt = ST_FETCH;
        case (state)
            ST_FETCH:    nxt = ST_DECODE;
            ST_DECODE: begin
                case (op_class)
                    CLS_R:   nxt = ST_R_EXE;
                    CLS_ORI: nxt = ST_ORI_EXE;
                    CLS_LW:  nxt = ST_LW_ADDR;
                    CLS_SW:  nxt = ST_SW_ADDR;
                    CLS_BEQ: nxt = ST_BEQ_CMP;
                    CLS_JMP: nxt = ST_JMP;
                    default: nxt = ST_EXC_UNDEF;
                endcase
            end
            ST_BEQ_CMP:  nxt = alu_equal ? ST_BEQ_TAKE : ST_FETCH;
            ST_R_EXE:    nxt = alu_ovf ? ST_EXC_OVF : ST_R_WB;
            ST_ORI_EXE:  nxt = ST_ORI_WB;
            ST_LW_ADDR:  nxt = ST_LW_MEM;
            ST_LW_MEM:   nxt = ST_LW_WB;
            ST_SW_ADDR:  nxt = ST_SW_MEM;
            default:     nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
    import mc_ctrl_pkg::*;
#(
    parameter int                 CAUSE_W   = 4,
    parameter logic [CAUSE_W-1:0] CAUSE_RI  = 4'd10,
    parameter logic [CAUSE_W-1:0] CAUSE_OVF = 4'd12
) (
    input  mc_state_t          state,
    output ctl_t               ctl,
    output logic [CAUSE_W-1:0] cause_code
);
    always_comb begin
        ctl = ctl_idle();
        case (state)
            ST_FETCH: begin
                ctl.mem_rd   = 1'b1;
                ctl.ir_wr    = 1'b1;
                ctl.alu_op   = ALU_ADD;
                ctl.srcb     = SRCB_FOUR;
                ctl.pc_wr    = 1'b1;
                ctl.pc_src   = PCS_ALU;
            end
            ST_BEQ_CMP: begin
                ctl.alu_op   = ALU_SUB;
                ctl.srca_reg = 1'b1;
                ctl.srcb     = SRCB_RT;
            end
            ST_BEQ_TAKE: begin
                ctl.alu_op   = ALU_ADD;
                ctl.srcb     = SRCB_SEXT_SH2;
                ctl.pc_wr    = 1'b1;
                ctl.pc_src   = PCS_ALU;
            end
            ST_R_EXE: begin
                ctl.alu_op   = ALU_FUNC;
                ctl.srca_reg = 1'b1;
                ctl.srcb     = SRCB_RT;
            end
            ST_R_WB: begin
                ctl.reg_wr   = 1'b1;
                ctl.dst_rd   = 1'b1;
            end
            ST_ORI_EXE: begin
                ctl.alu_op   = ALU_OR;
                ctl.srca_reg = 1'b1;
                ctl.srcb     = SRCB_ZEXT;
            end
            ST_ORI_WB:    ctl.reg_wr = 1'b1;
            ST_LW_ADDR,
            ST_SW_ADDR:   ctl = ctl_addr_calc();
            ST_LW_MEM: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_alu = 1'b1;
            end
            ST_LW_WB: begin
                ctl.reg_wr   = 1'b1;
                ctl.wb_mem   = 1'b1;
            end
            ST_SW_MEM: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_alu = 1'b1;
            end
            ST_JMP: begin
                ctl.pc_wr    = 1'b1;
                ctl.pc_src   = PCS_JUMP;
            end
            ST_EXC_UNDEF: ctl = ctl_exc_entry(1'b0);
            ST_EXC_OVF:   ctl = ctl_exc_entry(1'b1);
            default:      ctl = ctl_idle();
        endcase
    end

    always_comb begin
        cause_code = '0;
        if (ctl.cause_wr)
            cause_code = ctl.cause_ovf ? CAUSE_OVF : CAUSE_RI;
    end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_ctrl_pkg::*;
#(
    parameter int                 OP_W      = 6,
    parameter int                 CAUSE_W   = 4,
    parameter logic [OP_W-1:0]    OPC_R     = 6'b000000,
    parameter logic [OP_W-1:0]    OPC_ORI   = 6'b001101,
    parameter logic [OP_W-1:0]    OPC_LW    = 6'b100011,
    parameter logic [OP_W-1:0]    OPC_SW    = 6'b101011,
    parameter logic [OP_W-1:0]    OPC_BEQ   = 6'b000100,
    parameter logic [OP_W-1:0]    OPC_JMP   = 6'b000010,
    parameter logic [CAUSE_W-1:0] CAUSE_RI  = 4'd10,
    parameter logic [CAUSE_W-1:0] CAUSE_OVF = 4'd12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_W-1:0]    opcode,
    input  logic               alu_equal,
    input  logic               alu_ovf,
    output logic [3:0]         state_o,
    output logic [1:0]         alu_op,
    output logic               alu_a_sel,
    output logic [2:0]         alu_b_sel,
    output logic               reg_wr,
    output logic               reg_dst,
    output logic               wb_sel,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               addr_sel,
    output logic               ir_wr,
    output logic               pc_wr,
    output logic [1:0]         pc_src,
    output logic               epc_wr,
    output logic               cause_wr,
    output logic [CAUSE_W-1:0] cause_code
);
    mc_state_t state_q, state_d;
    op_class_t op_class;
    ctl_t      ctl;

    mc_opclass #(
        .OP_W(OP_W), .OPC_R(OPC_R), .OPC_ORI(OPC_ORI), .OPC_LW(OPC_LW),
        .OPC_SW(OPC_SW), .OPC_BEQ(OPC_BEQ), .OPC_JMP(OPC_JMP)
    ) u_cls (
        .opcode  (opcode),
        .op_class(op_class)
    );

    mc_next_state u_nxt (
        .state    (state_q),
        .op_class (op_class),
        .alu_equal(alu_equal),
        .alu_ovf  (alu_ovf),
        .nxt      (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    mc_out_decode #(
        .CAUSE_W(CAUSE_W), .CAUSE_RI(CAUSE_RI), .CAUSE_OVF(CAUSE_OVF)
    ) u_dec (
        .state     (state_q),
        .ctl       (ctl),
        .cause_code(cause_code)
    );

    assign state_o   = state_q;
    assign alu_op    = ctl.alu_op;
    assign alu_a_sel = ctl.srca_reg;
    assign alu_b_sel = ctl.srcb;
    assign reg_wr    = ctl.reg_wr;
    assign reg_dst   = ctl.dst_rd;
    assign wb_sel    = ctl.wb_mem;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign addr_sel  = ctl.addr_alu;
    assign ir_wr     = ctl.ir_wr;
    assign pc_wr     = ctl.pc_wr;
    assign pc_src    = ctl.pc_src;
    assign epc_wr    = ctl.epc_wr;
    assign cause_wr  = ctl.cause_wr;
endmodule

// File: rtl/mc_ctrl_checker.sv
module mc_ctrl_checker
    import mc_ctrl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] state_o,
    input logic       alu_equal,
    input logic       alu_ovf,
    input logic       reg_wr,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       pc_wr,
    input logic [1:0] pc_src,
    input logic       epc_wr,
    input logic       cause_wr
);
    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> state_o == ST_FETCH);

    assert_fetch_decode_R1: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_FETCH |=> state_o == ST_DECODE);

    assert_exc_return_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_EXC_UNDEF || state_o == ST_EXC_OVF) |=> state_o == ST_FETCH);

    assert_exc_controls_R3: assert property (@(posedge clk) disable iff (rst)
        epc_wr |-> (cause_wr && pc_wr && pc_src == PCS_EXC));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_R_EXE && alu_ovf) |=> (state_o == ST_EXC_OVF && !reg_wr));

    assert_ori_ovf_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_ORI_EXE |=> state_o == ST_ORI_WB);

    assert_beq_not_taken_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_BEQ_CMP && !alu_equal) |=> state_o == ST_FETCH);

    assert_mem_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind mc_ctrl mc_ctrl_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .state_o  (state_o),
    .alu_equal(alu_equal),
    .alu_ovf  (alu_ovf),
    .reg_wr   (reg_wr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .pc_wr    (pc_wr),
    .pc_src   (pc_src),
    .epc_wr   (epc_wr),
    .cause_wr (cause_wr)
);

// File: tb/mc_ctrl_test.sv
module mc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b000000;
    logic       alu_equal = 1'b0;
    logic       alu_ovf = 1'b0;
    logic [3:0] state_o;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [2:0] alu_b_sel;
    logic       reg_wr, reg_dst, wb_sel, mem_rd, mem_wr, addr_sel, ir_wr, pc_wr;
    logic [1:0] pc_src;
    logic       epc_wr, cause_wr;
    logic [3:0] cause_code;

    int checks = 0;
    int failures = 0;
    int ref_state = 0;

    always #5 clk = ~clk;

    mc_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_equal(alu_equal), .alu_ovf(alu_ovf),
        .state_o(state_o), .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .reg_wr(reg_wr), .reg_dst(reg_dst), .wb_sel(wb_sel), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr), .pc_wr(pc_wr),
        .pc_src(pc_src), .epc_wr(epc_wr), .cause_wr(cause_wr), .cause_code(cause_code)
    );

    // Reference transition function, written from the requirements.
    function automatic int ref_next(int s, logic [5:0] op, logic eq, logic ovf);
        if (s == 0) return 1;
        if (s == 1) begin
            if (op == 6'b000000) return 4;   // R2
            if (op == 6'b001101) return 6;
            if (op == 6'b100011) return 8;
            if (op == 6'b101011) return 11;
            if (op == 6'b000100) return 2;
            if (op == 6'b000010) return 13;
            return 14;                       // R3
        end
        if (s == 2)  return eq ? 3 : 0;      // R9
        if (s == 4)  return ovf ? 15 : 5;    // R4, R5
        if (s == 6)  return 7;               // R6
        if (s == 8)  return 9;               // R7
        if (s == 9)  return 10;
        if (s == 11) return 12;              // R8
        return 0;
    endfunction

    // Expected control word {alu_op, a, b, rw, dst, wb, mrd, mwr, addr, ir, pcw, pcs, epc, cw, code}.
    function automatic logic [21:0] exp_out(int s);
        logic [1:0] aop = 2'b00; logic sa = 0; logic [2:0] sb = 3'b000;
        logic rw = 0, dst = 0, wb = 0, mr = 0, mw = 0, ad = 0, ir = 0, pw = 0;
        logic [1:0] ps = 2'b00; logic ew = 0, cw = 0; logic [3:0] cc = 4'd0;
        case (s)
            0:  begin mr = 1; ir = 1; sb = 3'b001; pw = 1; end
            2:  begin aop = 2'b01; sa = 1; end
            3:  begin sb = 3'b011; pw = 1; end
            4:  begin aop = 2'b10; sa = 1; end
            5:  begin rw = 1; dst = 1; end
            6:  begin aop = 2'b11; sa = 1; sb = 3'b100; end
            7:  begin rw = 1; end
            8, 11: begin sa = 1; sb = 3'b010; end
            9:  begin mr = 1; ad = 1; end
            10: begin rw = 1; wb = 1; end
            12: begin mw = 1; ad = 1; end
            13: begin pw = 1; ps = 2'b10; end
            14: begin aop = 2'b01; sb = 3'b001; ew = 1; cw = 1; cc = 4'd10; pw = 1; ps = 2'b11; end
            15: begin aop = 2'b01; sb = 3'b001; ew = 1; cw = 1; cc = 4'd12; pw = 1; ps = 2'b11; end
            default: ;
        endcase
        return {aop, sa, sb, rw, dst, wb, mr, mw, ad, ir, pw, ps, ew, cw, cc};
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";  1: return "R11";
            2, 3: return "R9";  4, 5: return "R4";  6, 7: return "R6";
            8, 9, 10: return "R7";  11, 12: return "R8";
            13: return "R10";  14: return "R3";  15: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic compare();
        logic [21:0] act;
        act = {alu_op, alu_a_sel, alu_b_sel, reg_wr, reg_dst, wb_sel, mem_rd, mem_wr,
               addr_sel, ir_wr, pc_wr, pc_src, epc_wr, cause_wr, cause_code};
        checks++;
        if (state_o !== 4'(ref_state)) begin
            failures++;
            $display("FAIL %s state actual=%0d expected=%0d", tag_of(ref_state), state_o, ref_state);
        end
        checks++;
        if (act !== exp_out(ref_state)) begin
            failures++;
            $display("FAIL %s controls in state %0d actual=%h expected=%h",
                     tag_of(ref_state), ref_state, act, exp_out(ref_state));
        end
        checks++;
        if (mem_rd && mem_wr) begin
            failures++;
            $display("FAIL R11 mem strobes actual=11 expected=not both");
        end
    endtask

    task automatic step(input logic [5:0] op, input logic eq, input logic ovf);
        @(negedge clk);
        compare();
        opcode = op; alu_equal = eq; alu_ovf = ovf;
        ref_state = ref_next(ref_state, op, eq, ovf);
    endtask

    // Runs one instruction from fetch until the model is back in fetch.
    task automatic run_instr(input logic [5:0] op, input logic eq, input logic ovf);
        do step(op, eq, ovf); while (ref_state != 0);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare();
        rst = 1'b0;
        ref_state = ref_next(0, opcode, alu_equal, alu_ovf);

        // first instruction already in decode: R-type without overflow (R2, R4)
        do step(6'b000000, 1'b1, 1'b0); while (ref_state != 0);
        run_instr(6'b000000, 1'b0, 1'b1);   // R5: overflow diverts
        run_instr(6'b001101, 1'b0, 1'b1);   // R6: overflow ignored for OR-immediate
        run_instr(6'b100011, 1'b0, 1'b1);   // R7: load, flag not sampled
        run_instr(6'b101011, 1'b1, 1'b0);   // R8: store
        run_instr(6'b000100, 1'b1, 1'b0);   // R9: taken
        run_instr(6'b000100, 1'b0, 1'b0);   // R9: not taken
        run_instr(6'b000010, 1'b0, 1'b1);   // R10: jump
        run_instr(6'b111111, 1'b0, 1'b0);   // R3: undefined opcode
        run_instr(6'b000001, 1'b1, 1'b1);   // R3: another undefined opcode
        run_instr(6'b000000, 1'b0, 1'b0);   // R4 again after exceptions

        // R1: reset in the middle of a load
        step(6'b100011, 1'b0, 1'b0);
        step(6'b100011, 1'b0, 1'b0);
        step(6'b100011, 1'b0, 1'b0);
        @(negedge clk);
        compare();
        rst = 1'b1;
        ref_state = 0;
        @(negedge clk);
        compare();
        rst = 1'b0;
        ref_state = ref_next(0, opcode, alu_equal, alu_ovf);
        do step(6'b100011, 1'b0, 1'b0); while (ref_state != 0);
        @(negedge clk);
        compare();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule